// File: doc/BRIEF.md
# Interrupt Redirection Message Dispatcher

This block converts an interrupt line event into one or more interrupt messages for processors. A redirection table of `NUM_LINES` entries, programmed through an indexed register port, describes each line: a mask bit, an 8-bit vector, a 3-bit delivery mode, a destination-mode bit and an 8-bit destination. When a line event arrives, the block looks up that line's entry. Masked entries are dropped. Entries with a reserved delivery mode raise a one-cycle error pulse. All other entries produce a 32-bit trigger payload and one or more 64-bit target addresses.

In physical destination mode, one message goes to the processor named by the destination field. In logical mode, the destination field is an 8-bit bitmap of processor IDs. The block sends one unicast message for each set bit, starting at the lowest ID. All messages leave through a valid/ready channel that carries an address/payload pair. The block accepts a new event only while it is idle.

Top module: `irq_msg_dispatch`

## Requirements
- R1: After reset, every table entry reads back as masked (value 0x100000), and `msg_valid`, `busy` and `err_pulse` are low.
- R2: A cycle with `cfg_we` high stores `cfg_wdata` into the entry selected by `cfg_idx`. `cfg_rdata` always shows the entry at `cfg_idx`. The entry layout is: bit 20 mask, bit 19 destination mode (1 = logical), bits 18:16 delivery mode, bits 15:8 vector, bits 7:0 destination.
- R3: An event on a line whose entry has the mask bit set produces no message and no error, whatever the other fields hold.
- R4: The payload carries the destination in bits 7:0, the vector in bits 15:8, the delivery mode in bits 18:16 and the destination mode in bit 19. Bits 31:20 are zero.
- R5: In physical mode, exactly one message is sent, to address 0x2000_0000_0000_0000 OR (destination × 4096).
- R6: In logical mode, one message is sent for each set bit of the destination bitmap, in ascending bit order, addressed to that bit's ID. All of these messages carry the same payload. An all-zero bitmap sends nothing.
- R7: An unmasked entry with delivery mode 3 or 6 sends no message. It raises `err_pulse` for exactly one cycle, the cycle after the event, with `err_line` equal to the line index.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_payload` stay unchanged.
- R9: `busy` is high from the cycle after an event is accepted until the final message's handshake. Events that arrive while `busy` is high are ignored.
- R10: An event whose line index is `NUM_LINES` or above is ignored.
- R11: Rewriting a table entry while its messages are in flight does not change the messages still to be sent.
- R12: The first message of an accepted event is valid in the cycle right after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 5 | Table entry index for write and read |
| cfg_wdata | input | 21 | Entry value to write |
| cfg_rdata | output | 21 | Entry value at `cfg_idx` |
| line_evt | input | 1 | Line event strobe |
| line_idx | input | 5 | Index of the signalled line |
| busy | output | 1 | Message delivery in progress |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 64 | Target address of the message |
| msg_payload | output | 32 | Trigger payload |
| err_pulse | output | 1 | Reserved delivery mode detected |
| err_line | output | 5 | Line that caused the error |

## Verification
The hardest situation to reach is a logical fan-out that is stalled part way, with its table entry rewritten and a second event arriving during the stall. Reaching it needs backpressure on the output, a table write and a line event, all landing while `busy` is high. A directed sequence holds `msg_ready` low after the first message appears, fires a competing event, then rewrites the entry. It then releases `msg_ready` and compares the remaining stream against the payload captured when the event was accepted. A vector table also covers masked, reserved, empty-bitmap and full-bitmap entries.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

   localparam int unsigned DEST_W = 8;
   localparam int unsigned VEC_W  = 8;
   localparam int unsigned DM_W   = 3;

   typedef struct packed {
      logic              mask;
      logic              logical;
      logic [DM_W-1:0]   dmode;
      logic [VEC_W-1:0]  vec;
      logic [DEST_W-1:0] dest;
   } redir_ent_t;

   localparam int unsigned ENT_W = $bits(redir_ent_t);
   localparam int unsigned MSG_FIELD_W = ENT_W - 1;

   localparam logic [DM_W-1:0] DM_RSVD_LO = 3'd3;
   localparam logic [DM_W-1:0] DM_RSVD_HI = 3'd6;

   localparam redir_ent_t ENT_RESET = '{mask: 1'b1, logical: 1'b0, dmode: '0, vec: '0, dest: '0};

   function automatic logic dmode_reserved(input logic [DM_W-1:0] dm);
      return (dm == DM_RSVD_LO) || (dm == DM_RSVD_HI);
   endfunction

   function automatic logic [MSG_FIELD_W-1:0] msg_fields(input redir_ent_t e);
      return {e.logical, e.dmode, e.vec, e.dest};
   endfunction

endpackage

// File: rtl/irqd_redir_table.sv
module irqd_redir_table
   import irqd_pkg::*;
#(
   parameter int unsigned NUM_LINES = 24,
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  redir_ent_t       wr_ent,
   input  logic [IDX_W-1:0] rd_a_idx,
   output redir_ent_t       rd_a_ent,
   input  logic [IDX_W-1:0] rd_b_idx,
   output redir_ent_t       rd_b_ent,
   output logic             rd_b_inrange
);

   redir_ent_t mem [NUM_LINES];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[i] <= ENT_RESET;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            mem[i] <= wr_ent;
      end

      a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx == IDX_W'(i)) |=> (mem[i] == $past(wr_ent)));
   end

   always_comb begin
      rd_a_ent = ENT_RESET;
      rd_b_ent = ENT_RESET;
      rd_b_inrange = 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (rd_a_idx == IDX_W'(i))
            rd_a_ent = mem[i];
         if (rd_b_idx == IDX_W'(i)) begin
            rd_b_ent = mem[i];
            rd_b_inrange = 1'b1;
         end
      end
   end

endmodule

// File: rtl/irqd_low_pick.sv
module irqd_low_pick #(
   parameter int unsigned W = 8,
   localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
)(
   input  logic [W-1:0]  map,
   output logic [IW-1:0] low_idx,
   output logic [W-1:0]  low_onehot,
   output logic          any
);

   assign any = |map;

   if (W == 1) begin : g_single
      assign low_idx    = '0;
      assign low_onehot = map;
   end else begin : g_multi
      assign low_onehot = map & (~map + W'(1));
      always_comb begin
         low_idx = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (map[i])
               low_idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/irqd_fanout.sv
module irqd_fanout
   import irqd_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 24,
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned PAY_W      = 32,
   parameter int unsigned WIN_SHIFT  = 12,
   parameter logic [63:0] ADDR_BASE  = 64'h2000_0000_0000_0000,
   parameter int unsigned MSG_OFFSET = 0,
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int unsigned PID_W = (DEST_W > 1) ? $clog2(DEST_W) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic [IDX_W-1:0]  evt_idx,
   input  redir_ent_t        evt_ent,
   input  logic              evt_inrange,
   output logic              busy,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [ADDR_W-1:0] m_addr,
   output logic [PAY_W-1:0]  m_payload,
   output logic              err_pulse,
   output logic [IDX_W-1:0]  err_idx
);

   typedef enum logic {S_IDLE, S_SEND} fo_state_e;

   fo_state_e         st_q;
   logic              lg_q;
   logic [DEST_W-1:0] map_q;
   logic [DEST_W-1:0] phys_q;
   logic [PAY_W-1:0]  pay_q;
   logic              err_q;
   logic [IDX_W-1:0]  erri_q;

   logic [PID_W-1:0]  low_idx;
   logic [DEST_W-1:0] low_oh;
   logic              low_any;
   logic [DEST_W-1:0] map_rest;
   logic [DEST_W-1:0] cur_id;
   logic              take;
   logic              live;
   logic              xfer;

   irqd_low_pick #(.W(DEST_W)) u_pick (
      .map        (map_q),
      .low_idx    (low_idx),
      .low_onehot (low_oh),
      .any        (low_any)
   );

   assign take     = (st_q == S_IDLE) && evt && evt_inrange;
   assign live     = take && !evt_ent.mask;
   assign xfer     = (st_q == S_SEND) && m_ready;
   assign map_rest = map_q & ~low_oh;
   assign cur_id   = lg_q ? DEST_W'(low_idx) : phys_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         lg_q   <= 1'b0;
         map_q  <= '0;
         phys_q <= '0;
         pay_q  <= '0;
         err_q  <= 1'b0;
         erri_q <= '0;
      end else begin
         err_q <= 1'b0;
         if (live) begin
            if (dmode_reserved(evt_ent.dmode)) begin
               err_q  <= 1'b1;
               erri_q <= evt_idx;
            end else begin
               pay_q  <= PAY_W'(msg_fields(evt_ent));
               lg_q   <= evt_ent.logical;
               phys_q <= evt_ent.dest;
               map_q  <= evt_ent.dest;
               if (!evt_ent.logical || (evt_ent.dest != '0))
                  st_q <= S_SEND;
            end
         end else if (xfer) begin
            if (!lg_q) begin
               st_q <= S_IDLE;
            end else begin
               map_q <= map_rest;
               if (map_rest == '0)
                  st_q <= S_IDLE;
            end
         end
      end
   end

   assign busy      = (st_q == S_SEND);
   assign m_valid   = (st_q == S_SEND);
   assign m_payload = pay_q;
   assign m_addr    = ADDR_BASE[ADDR_W-1:0]
                    | (ADDR_W'(cur_id) << WIN_SHIFT)
                    | ADDR_W'(MSG_OFFSET);
   assign err_pulse = err_q;
   assign err_idx   = erri_q;

   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_payload)));

   a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready && lg_q && (map_rest != '0))
         |=> (m_valid && (m_addr[WIN_SHIFT +: DEST_W] > $past(m_addr[WIN_SHIFT +: DEST_W]))
              && $stable(m_payload)));

   a_r5_phys_single: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready && !lg_q) |=> !m_valid);

   a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> !m_valid);

   a_r9_busy_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && evt && !m_ready) |=> (busy && !err_pulse && $stable(m_payload)));

   a_r6_logical_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && lg_q) |-> low_any);

endmodule

// File: rtl/irq_msg_dispatch.sv
module irq_msg_dispatch
   import irqd_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 24,
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned PAY_W      = 32,
   parameter int unsigned WIN_SHIFT  = 12,
   parameter logic [63:0] ADDR_BASE  = 64'h2000_0000_0000_0000,
   parameter int unsigned MSG_OFFSET = 0,
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ENT_W-1:0]  cfg_wdata,
   output logic [ENT_W-1:0]  cfg_rdata,
   input  logic              line_evt,
   input  logic [IDX_W-1:0]  line_idx,
   output logic              busy,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [ADDR_W-1:0] msg_addr,
   output logic [PAY_W-1:0]  msg_payload,
   output logic              err_pulse,
   output logic [IDX_W-1:0]  err_line
);

   if (PAY_W < MSG_FIELD_W) begin : g_bad_pay
      $error("irq_msg_dispatch: PAY_W too narrow for message fields");
   end
   if (WIN_SHIFT + DEST_W > ADDR_W) begin : g_bad_win
      $error("irq_msg_dispatch: target window does not fit in ADDR_W");
   end
   if (ADDR_W > 64) begin : g_bad_addr
      $error("irq_msg_dispatch: ADDR_W above 64 not supported");
   end
   if (MSG_OFFSET >= (1 << WIN_SHIFT)) begin : g_bad_off
      $error("irq_msg_dispatch: MSG_OFFSET exceeds window");
   end

   redir_ent_t cfg_ent;
   redir_ent_t evt_ent;
   logic       evt_inrange;

   irqd_redir_table #(.NUM_LINES(NUM_LINES)) u_table (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (cfg_we),
      .wr_idx       (cfg_idx),
      .wr_ent       (redir_ent_t'(cfg_wdata)),
      .rd_a_idx     (cfg_idx),
      .rd_a_ent     (cfg_ent),
      .rd_b_idx     (line_idx),
      .rd_b_ent     (evt_ent),
      .rd_b_inrange (evt_inrange)
   );

   assign cfg_rdata = cfg_ent;

   irqd_fanout #(
      .NUM_LINES  (NUM_LINES),
      .ADDR_W     (ADDR_W),
      .PAY_W      (PAY_W),
      .WIN_SHIFT  (WIN_SHIFT),
      .ADDR_BASE  (ADDR_BASE),
      .MSG_OFFSET (MSG_OFFSET)
   ) u_fanout (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (line_evt),
      .evt_idx     (line_idx),
      .evt_ent     (evt_ent),
      .evt_inrange (evt_inrange),
      .busy        (busy),
      .m_valid     (msg_valid),
      .m_ready     (msg_ready),
      .m_addr      (msg_addr),
      .m_payload   (msg_payload),
      .err_pulse   (err_pulse),
      .err_idx     (err_line)
   );

endmodule

// File: tb/sim_irq_msg_dispatch.sv
module sim_irq_msg_dispatch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_idx = '0;
   logic [20:0] cfg_wdata = '0;
   logic [20:0] cfg_rdata;
   logic        line_evt = 1'b0;
   logic [4:0]  line_idx = '0;
   logic        busy;
   logic        msg_valid;
   logic        msg_ready = 1'b1;
   logic [63:0] msg_addr;
   logic [31:0] msg_payload;
   logic        err_pulse;
   logic [4:0]  err_line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_msg_dispatch u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .line_evt(line_evt), .line_idx(line_idx), .busy(busy),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
      .msg_payload(msg_payload), .err_pulse(err_pulse), .err_line(err_line)
   );

   // {line index[25:21], entry[20:0]}
   localparam logic [25:0] VECS [9] = '{
      {5'd0,  21'h003003},   // physical, fixed, vec 30, dest 3
      {5'd5,  21'h0841A5},   // logical bitmap A5
      {5'd23, 21'h105001},   // masked
      {5'd7,  21'h036002},   // reserved mode 3
      {5'd8,  21'h0E70FF},   // reserved mode 6, logical
      {5'd9,  21'h0C2200},   // logical, empty bitmap
      {5'd12, 21'h0F99FF},   // logical, all eight IDs
      {5'd2,  21'h051DFF},   // physical dest FF
      {5'd3,  21'h130101}    // masked with reserved mode
   };

   task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] tgt(input int id);
      return 64'h2000_0000_0000_0000 | (64'(id) << 12);
   endfunction

   task automatic wr(input logic [4:0] idx, input logic [20:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // leaves time at the negedge right after the event edge
   task automatic fire(input logic [4:0] idx);
      @(negedge clk);
      line_evt = 1'b1; line_idx = idx;
      @(negedge clk);
      line_evt = 1'b0;
   endtask

   task automatic collect(input int n, input int ids[8], input logic [31:0] pay, input string tag);
      int got = 0;
      chk(msg_valid == (n > 0), {"R12 first message timing ", tag}, 96'(msg_valid), 96'(n > 0));
      for (int c = 0; c < 14; c++) begin
         if (msg_valid) begin
            if (got < n) begin
               chk({msg_addr, msg_payload} == {tgt(ids[got]), pay}, tag,
                   {msg_addr, msg_payload}, {tgt(ids[got]), pay});
               chk(busy == 1'b1, {"R9 busy during send ", tag}, 96'(busy), 96'(1));
            end
            got++;
         end
         @(negedge clk);
      end
      chk(got == n, {"message count ", tag}, 96'(got), 96'(n));
      chk(busy == 1'b0, {"R9 busy clear ", tag}, 96'(busy), 96'(0));
   endtask

   task automatic run_vec(input logic [4:0] idx, input logic [20:0] e);
      int ids[8];
      int n = 0;
      bit rsv;
      bit live;
      logic [31:0] pay;
      string tag;
      rsv  = (e[18:16] == 3'd3) || (e[18:16] == 3'd6);
      live = !e[20];
      pay  = {12'b0, e[19:0]};
      for (int k = 0; k < 8; k++) ids[k] = 0;
      if (live && !rsv) begin
         if (!e[19]) begin ids[0] = int'(e[7:0]); n = 1; end
         else for (int b = 0; b < 8; b++) if (e[b]) begin ids[n] = b; n++; end
      end
      if (!live) tag = "R3 masked";
      else if (rsv) tag = "R7 reserved";
      else if (e[19]) tag = "R6 logical R4 payload";
      else tag = "R5 physical R4 payload";
      wr(idx, e);
      msg_ready = 1'b1;
      fire(idx);
      chk(err_pulse == (live && rsv), {"R7 err pulse ", tag}, 96'(err_pulse), 96'(live && rsv));
      if (live && rsv)
         chk(err_line == idx, "R7 err line", 96'(err_line), 96'(idx));
      collect(n, ids, pay, tag);
      if (live && rsv)
         chk(err_pulse == 1'b0, "R7 single cycle pulse", 96'(err_pulse), 96'(0));
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int ids[8];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!msg_valid && !busy && !err_pulse, "R1 outputs idle", 96'({msg_valid, busy, err_pulse}), 96'(0));
      for (int i = 0; i < 24; i++) begin
         cfg_idx = 5'(i);
         #1;
         chk(cfg_rdata == 21'h100000, "R1 entry masked", 96'(cfg_rdata), 96'(21'h100000));
      end

      // R2 write and read back
      wr(5'd17, 21'h0ABCDE);
      cfg_idx = 5'd17; #1;
      chk(cfg_rdata == 21'h0ABCDE, "R2 readback", 96'(cfg_rdata), 96'(21'h0ABCDE));
      cfg_idx = 5'd16; #1;
      chk(cfg_rdata == 21'h100000, "R2 neighbour untouched", 96'(cfg_rdata), 96'(21'h100000));

      // vector table
      for (int v = 0; v < 9; v++)
         run_vec(VECS[v][25:21], VECS[v][20:0]);

      // R8 / R9 / R11: stalled fan-out, competing event, table rewrite
      wr(5'd4, 21'h086105);   // logical bitmap 05, vec 61
      wr(5'd6, 21'h007706);   // physical dest 6, vec 77
      msg_ready = 1'b0;
      fire(5'd4);
      chk(msg_valid && msg_addr == tgt(0), "R12 stalled first", {msg_addr, 32'(msg_valid)}, {tgt(0), 32'd1});
      @(negedge clk);
      line_evt = 1'b1; line_idx = 5'd6;
      @(negedge clk);
      line_evt = 1'b0;
      cfg_we = 1'b1; cfg_idx = 5'd4; cfg_wdata = 21'h08EEF0;
      @(negedge clk);
      cfg_we = 1'b0;
      chk(msg_valid && msg_addr == tgt(0) && msg_payload == 32'h00086105, "R8 hold stable",
          {msg_addr, msg_payload}, {tgt(0), 32'h00086105});
      chk(busy == 1'b1, "R9 busy while stalled", 96'(busy), 96'(1));
      msg_ready = 1'b1;
      ids = '{0, 2, 0, 0, 0, 0, 0, 0};
      collect(2, ids, 32'h00086105, "R11 R9 in-flight unchanged, busy event ignored");

      // R10 out-of-range line
      fire(5'd30);
      ids = '{0, 0, 0, 0, 0, 0, 0, 0};
      chk(err_pulse == 1'b0, "R10 no error", 96'(err_pulse), 96'(0));
      collect(0, ids, 32'h0, "R10 out of range");

      // R11 new entry takes effect on next event
      fire(5'd4);
      ids = '{4, 5, 6, 7, 0, 0, 0, 0};
      collect(4, ids, 32'h0008EEF0, "R11 rewritten entry R6");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule